// File: doc/BRIEF.md
# Indexed-Colour Framebuffer Register Block

This block is the software-visible control plane of an 8-bit indexed-colour display controller. A 32-bit register bus writes and reads the display geometry, a control word, the frame start offset, the hardware cursor position, a 256-entry colour lookup table, a 3-entry cursor colour table and a 512-word cursor bitmap. The bus accepts byte, halfword and word accesses. Narrow writes merge into the addressed 32-bit word in the same cycle, and that word is then stored as a full word.

The stored state drives a pixel pipeline that sits outside this block. It gets the geometry, the control word, a pixel depth decoded from the control word, the frame offset, the cursor position, and combinational lookup ports into the three tables. A frame-completion pulse raises an interrupt, and the next register write of any kind lowers it. Writing to a dedicated soft-reset address returns all programmable state to zero.

Top module: `fbctl_regs`

## Requirements
- R1: The identifier word at byte address 0x0000 always reads 0x00000010, and writes to it change nothing.
- R2: A write of V to the horizontal register (0x1000) sets `cfg_width` to (V mod 2^(DIM_W-2))·4. A word read of that address returns `cfg_width`/4.
- R3: A write of V to the vertical register (0x1008) sets `cfg_height` to floor(V/2) within DIM_W bits. A read returns `cfg_height`·2, so an odd write reads back one lower.
- R4: The control word at 0x1010 holds all 32 bits and reads them back. `cfg_depth` follows control bits 22:20 as 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6→0, 7→0.
- R5: The colour table spans 0x2000..0x27FF, and the entry index is (address−0x2000)>>3. It stores red in bits 23:16, green in 15:8 and blue in 7:0. A read returns that packing with bits 31:24 at zero, and `pix_rgb` shows the entry chosen by `pix_index`.
- R6: The cursor colour table spans 0x1200..0x1217, with 3 entries and the same packing, read on `cur_rgb` by `cur_sel` (a value of 3 gives 0). The cursor bitmap spans 0x4000..0x4FFF with 512 entries that keep the low 16 data bits and read back zero-extended on the bus and on `pat_word`.
- R7: A byte write (`req_size`=0) replaces the lane selected by address bits 1:0 with `req_wdata[7:0]`. A halfword write (`req_size`=1) replaces the half selected by address bit 1 with `req_wdata[15:0]`. All other bits of the word are kept. Sizes 2 and 3 write the full word.
- R8: A byte read returns the lane selected by address bits 1:0 in bits 7:0. A halfword read returns the upper half when address bit 1 is set and the lower half otherwise, in bits 15:0. The remaining bits are zero.
- R9: Each read request gives `rd_valid` high for exactly the following cycle, with its data on `rd_data`. `rd_data` holds its value until the next read.
- R10: Any address outside the listed registers and tables reads as zero. Writes to such an address, including the timing window 0x1100..0x11FF, change no register.
- R11: A `frame_done` pulse sets `irq` in the next cycle. Any register write clears it in the next cycle. When both occur in the same cycle the pulse wins, and `irq` otherwise holds its value.
- R12: A write of any value to 0x1028 clears both colour tables, the cursor bitmap, the cursor position, the control word, the frame offset, the width, the height and `irq` by the next cycle. This clearing of `irq` overrides a same-cycle `frame_done`.
- R13: The frame offset (0x1018, the low TOP_W bits) and the cursor position (0x1020, the low CPOS_W bits) appear on `cfg_top` and `cfg_cursor_pos` and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W | Byte address within the register window |
| req_wdata | input | 32 | Write data (narrow data in the low bits) |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data, held between reads |
| frame_done | input | 1 | End-of-frame pulse from the display side |
| irq | output | 1 | Frame interrupt |
| cfg_width | output | DIM_W | Active width in pixels |
| cfg_height | output | DIM_W | Active height in lines |
| cfg_ctrl | output | 32 | Control word |
| cfg_depth | output | 5 | Decoded bits per pixel |
| cfg_top | output | TOP_W | Frame start offset |
| cfg_cursor_pos | output | CPOS_W | Cursor position word |
| pix_index | input | PIX_W | Colour table lookup index |
| pix_rgb | output | 24 | Colour table entry |
| cur_sel | input | CSEL_W | Cursor colour table index |
| cur_rgb | output | 24 | Cursor colour entry |
| pat_index | input | PAT_IW | Cursor bitmap index |
| pat_word | output | PAT_W | Cursor bitmap entry |

## Verification
The assertions assume that `rst_n` starts low, that at most one bus request arrives per cycle, and that inputs only change away from the rising edge. They treat `frame_done` as a free input that may coincide with a write; the interrupt properties state which event wins. The directed stimulus stays within these assumptions. It drives every request on the falling edge and holds it for exactly one cycle. It pulses `frame_done` separately and also together with a write, so that both priority rules of the interrupt are exercised.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;

   typedef enum logic [3:0] {
      RG_NONE, RG_ID, RG_HDISP, RG_VDISP, RG_CTRL, RG_TOP,
      RG_CPOS, RG_SRST, RG_CPAL, RG_PAL, RG_PAT
   } region_e;

   localparam logic [31:0] ID_VALUE = 32'h0000_0010;

   localparam int unsigned A_ID    = 32'h0000;
   localparam int unsigned A_HDISP = 32'h1000;
   localparam int unsigned A_VDISP = 32'h1008;
   localparam int unsigned A_CTRL  = 32'h1010;
   localparam int unsigned A_TOP   = 32'h1018;
   localparam int unsigned A_CPOS  = 32'h1020;
   localparam int unsigned A_SRST  = 32'h1028;
   localparam int unsigned A_CPAL  = 32'h1200;
   localparam int unsigned A_PAL   = 32'h2000;
   localparam int unsigned A_PAT   = 32'h4000;
   localparam int unsigned STRIDE  = 8;

   function automatic logic [4:0] depth_of(input logic [2:0] code);
      case (code)
         3'd0:    return 5'd1;
         3'd1:    return 5'd2;
         3'd2:    return 5'd4;
         3'd3:    return 5'd8;
         3'd4:    return 5'd15;
         3'd5:    return 5'd16;
         default: return 5'd0;
      endcase
   endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
   import fbctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned PAL_N  = 256,
   parameter int unsigned CPAL_N = 3,
   parameter int unsigned PAT_N  = 512,
   localparam int unsigned XW    = ADDR_W - 3
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [XW-1:0]     idx
);

   localparam logic [ADDR_W-1:0] CPAL_LO = ADDR_W'(A_CPAL);
   localparam logic [ADDR_W-1:0] CPAL_HI = ADDR_W'(A_CPAL + CPAL_N * STRIDE);
   localparam logic [ADDR_W-1:0] PAL_LO  = ADDR_W'(A_PAL);
   localparam logic [ADDR_W-1:0] PAL_HI  = ADDR_W'(A_PAL + PAL_N * STRIDE);
   localparam logic [ADDR_W-1:0] PAT_LO  = ADDR_W'(A_PAT);
   localparam logic [ADDR_W-1:0] PAT_HI  = ADDR_W'(A_PAT + PAT_N * STRIDE);

   logic [ADDR_W-1:0] wa;
   logic [ADDR_W-1:0] off;

   assign wa = {addr[ADDR_W-1:2], 2'b00};

   always_comb begin
      region = RG_NONE;
      off    = '0;
      if (wa == ADDR_W'(A_ID))           region = RG_ID;
      else if (wa == ADDR_W'(A_HDISP))   region = RG_HDISP;
      else if (wa == ADDR_W'(A_VDISP))   region = RG_VDISP;
      else if (wa == ADDR_W'(A_CTRL))    region = RG_CTRL;
      else if (wa == ADDR_W'(A_TOP))     region = RG_TOP;
      else if (wa == ADDR_W'(A_CPOS))    region = RG_CPOS;
      else if (wa == ADDR_W'(A_SRST))    region = RG_SRST;
      else if (wa >= CPAL_LO && wa < CPAL_HI) begin
         region = RG_CPAL;
         off    = wa - CPAL_LO;
      end else if (wa >= PAL_LO && wa < PAL_HI) begin
         region = RG_PAL;
         off    = wa - PAL_LO;
      end else if (wa >= PAT_LO && wa < PAT_HI) begin
         region = RG_PAT;
         off    = wa - PAT_LO;
      end
   end

   assign idx = XW'(off >> 3);

endmodule

// File: rtl/fbctl_lanes.sv
module fbctl_lanes
   import fbctl_pkg::*;
(
   input  logic [1:0]  size,
   input  logic [1:0]  lane,
   input  logic [31:0] old_word,
   input  logic [31:0] wdata,
   output logic [31:0] merged,
   output logic [31:0] rdata
);

   acc_size_e   sz;
   logic [3:0]  bsel;
   logic [31:0] src;

   assign sz = acc_size_e'(size);

   always_comb begin
      case (sz)
         SZ_BYTE: begin
            bsel = 4'b0001 << lane;
            src  = {4{wdata[7:0]}};
         end
         SZ_HALF: begin
            bsel = lane[1] ? 4'b1100 : 4'b0011;
            src  = {2{wdata[15:0]}};
         end
         default: begin
            bsel = 4'b1111;
            src  = wdata;
         end
      endcase
   end

   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign merged[8*g +: 8] = bsel[g] ? src[8*g +: 8] : old_word[8*g +: 8];
   end

   always_comb begin
      case (sz)
         SZ_BYTE: rdata = {24'b0, old_word[8*lane +: 8]};
         SZ_HALF: rdata = {16'b0, lane[1] ? old_word[31:16] : old_word[15:0]};
         default: rdata = old_word;
      endcase
   end

endmodule

// File: rtl/fbctl_table.sv
module fbctl_table #(
   parameter int unsigned N  = 256,
   parameter int unsigned W  = 24,
   parameter int unsigned XW = 13,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [XW-1:0] widx,
   input  logic [W-1:0]  wdata,
   input  logic [XW-1:0] ridx_a,
   output logic [W-1:0]  rdata_a,
   input  logic [IW-1:0] ridx_b,
   output logic [W-1:0]  rdata_b
);

   logic [W-1:0]  mem [N];
   logic [IW-1:0] wsel;
   logic [IW-1:0] asel;
   logic          w_ok;
   logic          a_ok;

   assign wsel = widx[IW-1:0];
   assign asel = ridx_a[IW-1:0];
   assign w_ok = widx < XW'(N);
   assign a_ok = ridx_a < XW'(N);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(N); i++) mem[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < int'(N); i++) mem[i] <= '0;
      end else if (we && w_ok) begin
         mem[wsel] <= wdata;
      end
   end

   assign rdata_a = a_ok ? mem[asel] : '0;
   assign rdata_b = (32'(ridx_b) < N) ? mem[ridx_b] : '0;

endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
   import fbctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DIM_W  = 14,
   parameter int unsigned TOP_W  = 23,
   parameter int unsigned CPOS_W = 24,
   parameter int unsigned PAL_N  = 256,
   parameter int unsigned CPAL_N = 3,
   parameter int unsigned PAT_N  = 512,
   parameter int unsigned PAT_W  = 16,
   localparam int unsigned PIX_W  = $clog2(PAL_N),
   localparam int unsigned CSEL_W = (CPAL_N > 1) ? $clog2(CPAL_N) : 1,
   localparam int unsigned PAT_IW = $clog2(PAT_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   input  logic              frame_done,
   output logic              irq,
   output logic [DIM_W-1:0]  cfg_width,
   output logic [DIM_W-1:0]  cfg_height,
   output logic [31:0]       cfg_ctrl,
   output logic [4:0]        cfg_depth,
   output logic [TOP_W-1:0]  cfg_top,
   output logic [CPOS_W-1:0] cfg_cursor_pos,
   input  logic [PIX_W-1:0]  pix_index,
   output logic [23:0]       pix_rgb,
   input  logic [CSEL_W-1:0] cur_sel,
   output logic [23:0]       cur_rgb,
   input  logic [PAT_IW-1:0] pat_index,
   output logic [PAT_W-1:0]  pat_word
);

   localparam int unsigned XW = ADDR_W - 3;

   if (PAL_N * STRIDE > A_PAT - A_PAL) begin : g_bad_pal
      $error("colour table does not fit its window");
   end
   if (CPAL_N * STRIDE > A_PAL - A_CPAL) begin : g_bad_cpal
      $error("cursor colour table does not fit its window");
   end
   if (A_PAT + PAT_N * STRIDE > (1 << ADDR_W)) begin : g_bad_pat
      $error("cursor bitmap exceeds the address window");
   end
   if (DIM_W < 3 || DIM_W > 31) begin : g_bad_dim
      $error("DIM_W out of range");
   end
   if (TOP_W > 32 || CPOS_W > 32 || PAT_W > 32 || PAT_W == 0) begin : g_bad_w
      $error("field width out of range");
   end

   region_e           rg;
   logic [XW-1:0]     idx;
   logic              wr_fire;
   logic              rd_fire;
   logic              srst;
   logic [31:0]       cur_word;
   logic [31:0]       merged;
   logic [31:0]       rsub;
   logic [23:0]       pal_rd;
   logic [23:0]       cpal_rd;
   logic [PAT_W-1:0]  pat_rd;

   logic [DIM_W-1:0]  width_q;
   logic [DIM_W-1:0]  height_q;
   logic [31:0]       ctrl_q;
   logic [TOP_W-1:0]  top_q;
   logic [CPOS_W-1:0] cpos_q;

   fbctl_decode #(
      .ADDR_W(ADDR_W), .PAL_N(PAL_N), .CPAL_N(CPAL_N), .PAT_N(PAT_N)
   ) u_dec (
      .addr(req_addr), .region(rg), .idx(idx)
   );

   assign wr_fire = req_valid && req_write;
   assign rd_fire = req_valid && !req_write;
   assign srst    = wr_fire && (rg == RG_SRST);

   always_comb begin
      case (rg)
         RG_ID:    cur_word = ID_VALUE;
         RG_HDISP: cur_word = 32'(width_q[DIM_W-1:2]);
         RG_VDISP: cur_word = 32'({height_q, 1'b0});
         RG_CTRL:  cur_word = ctrl_q;
         RG_TOP:   cur_word = 32'(top_q);
         RG_CPOS:  cur_word = 32'(cpos_q);
         RG_CPAL:  cur_word = 32'(cpal_rd);
         RG_PAL:   cur_word = 32'(pal_rd);
         RG_PAT:   cur_word = 32'(pat_rd);
         default:  cur_word = 32'h0;
      endcase
   end

   fbctl_lanes u_lanes (
      .size(req_size), .lane(req_addr[1:0]), .old_word(cur_word),
      .wdata(req_wdata), .merged(merged), .rdata(rsub)
   );

   fbctl_table #(.N(PAL_N), .W(24), .XW(XW)) u_pal (
      .clk(clk), .rst_n(rst_n), .clr(srst),
      .we(wr_fire && rg == RG_PAL), .widx(idx), .wdata(merged[23:0]),
      .ridx_a(idx), .rdata_a(pal_rd), .ridx_b(pix_index), .rdata_b(pix_rgb)
   );

   fbctl_table #(.N(CPAL_N), .W(24), .XW(XW)) u_cpal (
      .clk(clk), .rst_n(rst_n), .clr(srst),
      .we(wr_fire && rg == RG_CPAL), .widx(idx), .wdata(merged[23:0]),
      .ridx_a(idx), .rdata_a(cpal_rd), .ridx_b(cur_sel), .rdata_b(cur_rgb)
   );

   fbctl_table #(.N(PAT_N), .W(PAT_W), .XW(XW)) u_pat (
      .clk(clk), .rst_n(rst_n), .clr(srst),
      .we(wr_fire && rg == RG_PAT), .widx(idx), .wdata(merged[PAT_W-1:0]),
      .ridx_a(idx), .rdata_a(pat_rd), .ridx_b(pat_index), .rdata_b(pat_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q  <= '0;
         height_q <= '0;
         ctrl_q   <= '0;
         top_q    <= '0;
         cpos_q   <= '0;
      end else if (srst) begin
         width_q  <= '0;
         height_q <= '0;
         ctrl_q   <= '0;
         top_q    <= '0;
         cpos_q   <= '0;
      end else if (wr_fire) begin
         case (rg)
            RG_HDISP: width_q  <= {merged[DIM_W-3:0], 2'b00};
            RG_VDISP: height_q <= merged[DIM_W:1];
            RG_CTRL:  ctrl_q   <= merged;
            RG_TOP:   top_q    <= merged[TOP_W-1:0];
            RG_CPOS:  cpos_q   <= merged[CPOS_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          irq <= 1'b0;
      else if (srst)       irq <= 1'b0;
      else if (frame_done) irq <= 1'b1;
      else if (wr_fire)    irq <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_fire;
         if (rd_fire) rd_data <= rsub;
      end
   end

   assign cfg_width      = width_q;
   assign cfg_height     = height_q;
   assign cfg_ctrl       = ctrl_q;
   assign cfg_depth      = depth_of(ctrl_q[22:20]);
   assign cfg_top        = top_q;
   assign cfg_cursor_pos = cpos_q;

endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk
   import fbctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DIM_W  = 14,
   parameter int unsigned TOP_W  = 23,
   parameter int unsigned CPOS_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [1:0]        req_size,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rd_valid,
   input logic [31:0]       rd_data,
   input logic              frame_done,
   input logic              irq,
   input logic [DIM_W-1:0]  cfg_width,
   input logic [DIM_W-1:0]  cfg_height,
   input logic [31:0]       cfg_ctrl,
   input logic [4:0]        cfg_depth,
   input logic [TOP_W-1:0]  cfg_top,
   input logic [CPOS_W-1:0] cfg_cursor_pos
);

   logic wr_req;
   logic rd_req;
   logic [ADDR_W-1:0] wa;

   assign wr_req = req_valid && req_write;
   assign rd_req = req_valid && !req_write;
   assign wa     = {req_addr[ADDR_W-1:2], 2'b00};

   a_r11_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !(wr_req && wa == ADDR_W'(A_SRST))) |=> irq);

   a_r11_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !frame_done) |=> !irq);

   a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_done && !wr_req) |=> $stable(irq));

   a_r9_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

   a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rd_data));

   a_r1_id_word: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && req_size == 2'd2 && wa == ADDR_W'(A_ID)) |=> rd_data == ID_VALUE);

   a_r12_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wa == ADDR_W'(A_SRST)) |=>
      (cfg_width == '0 && cfg_height == '0 && cfg_ctrl == '0 &&
       cfg_top == '0 && cfg_cursor_pos == '0 && !irq));

   a_r4_depth_eight: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ctrl[22:20] == 3'd3) |-> cfg_depth == 5'd8);

   a_r4_depth_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ctrl[22] && cfg_ctrl[21]) |-> cfg_depth == 5'd0);

endmodule

bind fbctl_regs fbctl_regs_chk #(
   .ADDR_W(ADDR_W), .DIM_W(DIM_W), .TOP_W(TOP_W), .CPOS_W(CPOS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_size(req_size), .req_addr(req_addr), .rd_valid(rd_valid),
   .rd_data(rd_data), .frame_done(frame_done), .irq(irq),
   .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_ctrl(cfg_ctrl),
   .cfg_depth(cfg_depth), .cfg_top(cfg_top), .cfg_cursor_pos(cfg_cursor_pos)
);

// File: tb/fbctl_regs_test.sv
module fbctl_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd2;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        frame_done = 1'b0;
   logic        irq;
   logic [13:0] cfg_width;
   logic [13:0] cfg_height;
   logic [31:0] cfg_ctrl;
   logic [4:0]  cfg_depth;
   logic [22:0] cfg_top;
   logic [23:0] cfg_cursor_pos;
   logic [7:0]  pix_index = '0;
   logic [23:0] pix_rgb;
   logic [1:0]  cur_sel = '0;
   logic [23:0] cur_rgb;
   logic [8:0]  pat_index = '0;
   logic [15:0] pat_word;

   int checks = 0;
   int fails  = 0;

   localparam logic [15:0] AD_ID = 16'h0000, AD_H = 16'h1000, AD_V = 16'h1008,
      AD_CTRL = 16'h1010, AD_TOP = 16'h1018, AD_CPOS = 16'h1020, AD_SRST = 16'h1028,
      AD_CPAL = 16'h1200, AD_PAL = 16'h2000, AD_PAT = 16'h4000;

   always #5 clk = ~clk;

   fbctl_regs uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .frame_done(frame_done), .irq(irq),
      .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_ctrl(cfg_ctrl),
      .cfg_depth(cfg_depth), .cfg_top(cfg_top), .cfg_cursor_pos(cfg_cursor_pos),
      .pix_index(pix_index), .pix_rgb(pix_rgb), .cur_sel(cur_sel), .cur_rgb(cur_rgb),
      .pat_index(pat_index), .pat_word(pat_word)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [1:0] sz, output logic [31:0] q);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 rd_valid after read", 32'(rd_valid), 32'd1);
      q = rd_data;
   endtask

   task automatic t_reset;
      logic [31:0] q;
      chk("R11 irq after reset", 32'(irq), 0);
      chk("R2 width after reset", 32'(cfg_width), 0);
      chk("R9 rd_valid idle", 32'(rd_valid), 0);
      rd(AD_ID, 2'd2, q);
      chk("R1 id word", q, 32'h10);
   endtask

   task automatic t_id;
      logic [31:0] q;
      wr(AD_ID, 2'd2, 32'h5555_5555);
      rd(AD_ID, 2'd2, q);
      chk("R1 id after write", q, 32'h10);
      rd(AD_ID + 16'd1, 2'd0, q);
      chk("R1 id lane1", q, 32'h0);
   endtask

   task automatic t_dims;
      logic [31:0] q;
      wr(AD_H, 2'd2, 32'h140);
      chk("R2 width", 32'(cfg_width), 32'd1280);
      rd(AD_H, 2'd2, q);
      chk("R2 width readback", q, 32'h140);
      wr(AD_H, 2'd2, 32'h1005);
      chk("R2 width wrap", 32'(cfg_width), 32'h14);
      wr(AD_V, 2'd2, 32'h3C1);
      chk("R3 height", 32'(cfg_height), 32'd480);
      rd(AD_V, 2'd2, q);
      chk("R3 height readback odd", q, 32'h3C0);
   endtask

   task automatic t_ctrl;
      logic [31:0] q;
      logic [4:0] tbl [8];
      tbl = '{5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16, 5'd0, 5'd0};
      for (int c = 0; c < 8; c++) begin
         wr(AD_CTRL, 2'd2, 32'h0000_0400 | (32'(c) << 20));
         chk("R4 depth", 32'(cfg_depth), 32'(tbl[c]));
      end
      wr(AD_CTRL, 2'd2, 32'hC0F3_0401);
      rd(AD_CTRL, 2'd2, q);
      chk("R4 ctrl readback", q, 32'hC0F3_0401);
   endtask

   task automatic t_pal;
      logic [31:0] q;
      wr(AD_PAL + 16'h28, 2'd2, 32'hAB12_3456);
      rd(AD_PAL + 16'h28, 2'd2, q);
      chk("R5 palette readback", q, 32'h0012_3456);
      wr(AD_PAL + 16'h7F8, 2'd2, 32'h00FE_DCBA);
      pix_index = 8'd5; #1;
      chk("R5 pixel lookup 5", 32'(pix_rgb), 32'h12_3456);
      pix_index = 8'd255; #1;
      chk("R5 pixel lookup 255", 32'(pix_rgb), 32'hFE_DCBA);
      pix_index = 8'd6; #1;
      chk("R5 untouched entry", 32'(pix_rgb), 32'h0);
   endtask

   task automatic t_cursor;
      logic [31:0] q;
      wr(AD_CPAL + 16'h10, 2'd2, 32'h00FF_8001);
      cur_sel = 2'd2; #1;
      chk("R6 cursor colour 2", 32'(cur_rgb), 32'hFF_8001);
      cur_sel = 2'd3; #1;
      chk("R6 cursor colour 3", 32'(cur_rgb), 32'h0);
      wr(AD_PAT + 16'hFF8, 2'd2, 32'hDEAD_BEEF);
      rd(AD_PAT + 16'hFF8, 2'd2, q);
      chk("R6 bitmap readback", q, 32'h0000_BEEF);
      pat_index = 9'd511; #1;
      chk("R6 bitmap lookup", 32'(pat_word), 32'hBEEF);
   endtask

   task automatic t_subword;
      logic [31:0] q;
      wr(AD_CTRL, 2'd2, 32'h1122_3344);
      wr(AD_CTRL + 16'd2, 2'd0, 32'hFFFF_FFAA);
      chk("R7 byte lane2 write", cfg_ctrl, 32'h11AA_3344);
      wr(AD_CTRL + 16'd2, 2'd1, 32'hFFFF_5566);
      chk("R7 upper half write", cfg_ctrl, 32'h5566_3344);
      wr(AD_CTRL, 2'd1, 32'h0000_7788);
      chk("R7 lower half write", cfg_ctrl, 32'h5566_7788);
      wr(AD_PAL + 16'h29, 2'd0, 32'h0000_00EE);
      pix_index = 8'd5; #1;
      chk("R7 byte write into palette", 32'(pix_rgb), 32'h12_EE56);
      rd(AD_CTRL, 2'd0, q);
      chk("R8 byte lane0", q, 32'h88);
      rd(AD_CTRL + 16'd3, 2'd0, q);
      chk("R8 byte lane3", q, 32'h55);
      rd(AD_CTRL + 16'd2, 2'd1, q);
      chk("R8 upper half", q, 32'h5566);
      rd(AD_CTRL, 2'd1, q);
      chk("R8 lower half", q, 32'h7788);
   endtask

   task automatic t_hold;
      logic [31:0] q;
      rd(AD_CTRL, 2'd2, q);
      @(negedge clk);
      chk("R9 rd_valid drops", 32'(rd_valid), 0);
      wr(AD_CTRL, 2'd2, 32'h0);
      @(negedge clk);
      chk("R9 data held", rd_data, 32'h5566_7788);
   endtask

   task automatic t_unknown;
      logic [31:0] q;
      wr(AD_CTRL, 2'd2, 32'h0123_4567);
      wr(16'h1108, 2'd2, 32'hFFFF_FFFF);
      wr(16'h1004, 2'd2, 32'hFFFF_FFFF);
      chk("R10 ctrl untouched", cfg_ctrl, 32'h0123_4567);
      chk("R10 width untouched", 32'(cfg_width), 32'h14);
      rd(16'h1108, 2'd2, q);
      chk("R10 timing reads zero", q, 0);
      rd(16'h1004, 2'd2, q);
      chk("R10 gap reads zero", q, 0);
   endtask

   task automatic t_top;
      logic [31:0] q;
      wr(AD_TOP, 2'd2, 32'hFFFF_FFFF);
      chk("R13 top field", 32'(cfg_top), 32'h007F_FFFF);
      rd(AD_TOP, 2'd2, q);
      chk("R13 top readback", q, 32'h007F_FFFF);
      wr(AD_CPOS, 2'd2, 32'hAB12_3456);
      chk("R13 cursor pos", 32'(cfg_cursor_pos), 32'h12_3456);
      rd(AD_CPOS, 2'd2, q);
      chk("R13 cursor pos readback", q, 32'h0012_3456);
   endtask

   task automatic t_irq;
      logic [31:0] q;
      frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
      chk("R11 irq set", 32'(irq), 1);
      rd(AD_ID, 2'd2, q);
      repeat (3) @(negedge clk);
      chk("R11 irq holds over read", 32'(irq), 1);
      wr(16'h1100, 2'd2, 32'h0);
      chk("R11 write clears", 32'(irq), 0);
      frame_done = 1'b1;
      wr(16'h1100, 2'd2, 32'h0);
      frame_done = 1'b0;
      chk("R11 frame wins over write", 32'(irq), 1);
   endtask

   task automatic t_srst;
      logic [31:0] q;
      frame_done = 1'b1;
      wr(AD_SRST, 2'd0, 32'h0);
      frame_done = 1'b0;
      chk("R12 irq cleared", 32'(irq), 0);
      chk("R12 width", 32'(cfg_width), 0);
      chk("R12 height", 32'(cfg_height), 0);
      chk("R12 ctrl", cfg_ctrl, 0);
      chk("R12 top", 32'(cfg_top), 0);
      chk("R12 cursor pos", 32'(cfg_cursor_pos), 0);
      pix_index = 8'd255; cur_sel = 2'd2; pat_index = 9'd511; #1;
      chk("R12 palette cleared", 32'(pix_rgb), 0);
      chk("R12 cursor colour cleared", 32'(cur_rgb), 0);
      chk("R12 bitmap cleared", 32'(pat_word), 0);
      rd(AD_PAL + 16'h28, 2'd2, q);
      chk("R12 palette read zero", q, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_id();
      t_dims();
      t_ctrl();
      t_pal();
      t_cursor();
      t_subword();
      t_hold();
      t_unknown();
      t_top();
      t_irq();
      t_srst();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule